// File: doc/BRIEF.md
# I2C Serial Byte-Store Target with Persistent Read Pointer

This block is an I2C target that behaves like a serial byte-addressable store. It oversamples SCL and SDA with a fast system clock and recognises START, repeated START and STOP. It matches a fixed 7-bit device address and takes the direction bit that follows it. A write transfer carries a two-byte word address that loads an internal read pointer. A read transfer streams bytes from the array at that pointer. SDA is driven only as an open-drain enable: while `sda_oe` is high the line is pulled low.

The read pointer is the central state. It always holds the address one past the last byte served, or the address most recently loaded. A read with no address phase therefore continues where the previous access stopped. A master ACK asks for the next byte. When the pointer passes the top of the array it wraps to zero. The array size is set by `AW`: 13 gives the 8192-byte organisation, and the default of 10 keeps elaboration small. The contents are a fixed computed pattern, because programming is outside this block.

Top module: `eep_i2c_target`

## Requirements
- R1: After reset the pointer is 0 and `sda_oe` is low.
- R2: The target ACKs a device byte whose upper 7 bits equal `DEV_ADDR`, either direction (bit 0: 1 = read, 0 = write). Any other device byte is NACKed, and the target then leaves SDA released for every later byte until the next START.
- R3: In a write transfer, the two bytes after the device byte are ACKed and form the word address, high byte first. Only the low `AW` bits load the pointer, and the upper bits are ignored. A repeated START and a read device byte then return the byte at that address.
- R4: The byte at address a is ((a mod 256) * 7 mod 256) XOR (a div 256) XOR 0xA5, shifted out MSB first.
- R5: When the master ACKs a data byte, the target sends the byte at the next address.
- R6: A read with no address phase returns the byte at the pointer. The pointer is the address loaded, or one past the last byte sent.
- R7: After the byte at address 2^AW-1 the pointer wraps to 0, and streaming continues.
- R8: After a master NACK the target releases SDA, and it drives nothing further until the next START.
- R9: A write byte after the two address bytes is NACKed, and it alters neither the pointer nor the array.
- R10: The target changes its SDA drive only while SCL is low.
- R11: A write transfer stopped before the low address byte has completed leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when high (open-drain enable) |

## Verification
A wrong pointer is invisible until the next read. It then shows as a wrong byte, one transfer after the fault, so every scenario ends with a current-address read that exposes the pointer. A wrong state in the transfer sequencer shows within one SCL period as a missing or spurious ACK, or as SDA held low where the master expects release. For that reason the bench samples the line at every acknowledge slot and on a byte clocked after a NACK. Pattern and wrap faults show in the data bytes read across the top of the array.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_AHI, S_HACK,
    S_ALO, S_LACK, S_TX, S_MACK, S_IGN
  } eep_state_e;

  // Fixed array contents; the address is zero-extended to 16 bits.
  function automatic logic [7:0] cell_value(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd7;
    return m ^ a[15:8] ^ 8'hA5;
  endfunction

endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC_STAGES:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s    = scl_sh[SYNC_STAGES-1];
  assign sda_s    = sda_sh[SYNC_STAGES-1];
  assign scl_d    = scl_sh[SYNC_STAGES];
  assign sda_d    = sda_sh[SYNC_STAGES];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_addr_counter.sv
module eep_addr_counter #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] value
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == TOP) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (inc)  value <= step(value);
  end

  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && value == TOP) |=> (value == '0));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(value));

endmodule

// File: rtl/eep_byte_array.sv
module eep_byte_array #(
  parameter int AW = 10
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  import eep_pkg::*;
  assign data = cell_value(16'(addr));
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
  import eep_pkg::*;
#(
  parameter int          AW          = 10,
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  eep_state_e state;
  logic [3:0]    bitcnt;
  logic [7:0]    rx, hi_q, tx, rd_data;
  logic          rw_q, macked;
  logic [AW-1:0] ptr;
  logic          ptr_load, ptr_inc, byte_done, dev_hit;

  eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p));

  eep_addr_counter #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load),
    .load_val(AW'({hi_q, rx})), .inc(ptr_inc), .value(ptr));

  eep_byte_array #(.AW(AW)) u_arr (.addr(ptr), .data(rd_data));

  assign byte_done = (bitcnt == 4'd8);
  assign dev_hit   = (rx[7:1] == DEV_ADDR);
  assign ptr_load  = scl_fall && state == S_ALO && byte_done;
  assign ptr_inc   = scl_fall && ((state == S_DACK && rw_q) ||
                                  (state == S_MACK && macked));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      rx     <= '0;
      hi_q   <= '0;
      tx     <= '0;
      rw_q   <= 1'b0;
      macked <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_p) begin
      state  <= S_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_p) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        S_DEV, S_AHI, S_ALO:
          if (!byte_done) begin
            rx     <= {rx[6:0], sda_s};
            bitcnt <= 4'(bitcnt + 4'd1);
          end
        S_TX:   bitcnt <= 4'(bitcnt + 4'd1);
        S_MACK: macked <= ~sda_s;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state)
        S_DEV:
          if (byte_done) begin
            bitcnt <= '0;
            rw_q   <= rx[0];
            if (dev_hit) begin
              sda_oe <= 1'b1;
              state  <= S_DACK;
            end else begin
              state  <= S_IGN;
            end
          end
        S_DACK:
          if (rw_q) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[7];
            bitcnt <= '0;
            state  <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= S_AHI;
          end
        S_AHI:
          if (byte_done) begin
            hi_q   <= rx;
            sda_oe <= 1'b1;
            bitcnt <= '0;
            state  <= S_HACK;
          end
        S_HACK: begin
          sda_oe <= 1'b0;
          state  <= S_ALO;
        end
        S_ALO:
          if (byte_done) begin
            sda_oe <= 1'b1;
            bitcnt <= '0;
            state  <= S_LACK;
          end
        S_LACK: begin
          sda_oe <= 1'b0;
          state  <= S_IGN;
        end
        S_TX:
          if (byte_done) begin
            sda_oe <= 1'b0;
            state  <= S_MACK;
          end else begin
            sda_oe <= ~tx[6];
            tx     <= {tx[6:0], 1'b0};
          end
        S_MACK:
          if (macked) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[7];
            bitcnt <= '0;
            state  <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            state  <= S_IGN;
          end
        default: ;
      endcase
    end
  end

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe) && !$past(start_p) && !$past(stop_p)) |-> !scl_s);

  a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IGN) |-> !sda_oe);

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_oe);

  a_r5_step_starts_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc |=> (state == S_TX));

  a_r3_load_takes_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (ptr == AW'($past({hi_q, rx}))));

endmodule

// File: tb/test_eep_i2c_target.sv
module test_eep_i2c_target;
  localparam int CLK_NS = 10;
  localparam int Q      = 10;
  localparam int AW     = 10;
  localparam int DEPTH  = 1 << AW;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0, fails = 0, ptr = 0, viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  eep_i2c_target #(.AW(AW), .DEV_ADDR(DEV)) i_eep_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe));

  // R10 monitor: the drive may not change while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe !== prev_oe) viol++;
    prev_oe = sda_oe;
  end

  function automatic int exp_cell(int a);
    return (((a % 256) * 7) % 256) ^ (a / 256) ^ 165;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q/2);
    ack = ~sda_line;
    tick(Q/2); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q/2); b[i] = sda_line; tick(Q/2); scl_m = 1'b0;
    end
    sda_m = ~give_ack; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_pointer(int waddr, string req);
    logic a;
    bus_start;
    put_byte({DEV, 1'b0}, a); chk({req, " device write ACK"}, a, 1);
    put_byte(8'(waddr >> 8), a); chk({req, " high address ACK"}, a, 1);
    put_byte(8'(waddr), a);      chk({req, " low address ACK"}, a, 1);
    ptr = waddr % DEPTH;
  endtask

  task automatic read_run(int n, string req);
    logic a;
    logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b1}, a); chk({req, " device read ACK"}, a, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(d, k < n - 1);
      chk({req, " data"}, d, exp_cell(ptr));
      ptr = (ptr + 1) % DEPTH;
    end
    bus_stop;
  endtask

  task automatic t_reset;
    chk("R1 sda released after reset", sda_oe, 0);
    read_run(1, "R1 pointer starts at zero");
  endtask

  task automatic t_random;
    set_pointer(16'h0123, "R3");
    read_run(1, "R3 R4 random read");
    set_pointer(16'hFC05, "R3 upper bits");
    read_run(1, "R3 upper address bits ignored");
  endtask

  task automatic t_sequential;
    set_pointer(16'h02F0, "R5");
    read_run(5, "R5 sequential");
    read_run(2, "R6 current-address read");
  endtask

  task automatic t_wrap;
    set_pointer(DEPTH - 2, "R7");
    read_run(3, "R7 wrap across top");
    read_run(1, "R7 R6 after wrap");
  endtask

  task automatic t_mismatch;
    logic a;
    bus_start;
    put_byte({7'h51, 1'b0}, a); chk("R2 foreign address NACK", a, 0);
    put_byte(8'h00, a);         chk("R2 bus ignored after mismatch", a, 0);
    bus_stop;
    read_run(1, "R2 pointer kept after mismatch");
  endtask

  task automatic t_master_nack;
    logic a;
    logic [7:0] d;
    bus_start;
    put_byte({DEV, 1'b1}, a); chk("R8 device read ACK", a, 1);
    get_byte(d, 1'b0); chk("R8 data", d, exp_cell(ptr));
    ptr = (ptr + 1) % DEPTH;
    chk("R8 released after NACK", sda_oe, 0);
    get_byte(d, 1'b0); chk("R8 no drive after NACK", d, 8'hFF);
    bus_stop;
    read_run(1, "R8 pointer after NACK");
  endtask

  task automatic t_extra_write;
    logic a;
    set_pointer(16'h0040, "R9");
    put_byte(8'h3C, a); chk("R9 data byte NACK", a, 0);
    bus_stop;
    read_run(1, "R9 array and pointer unchanged");
  endtask

  task automatic t_cut_dummy;
    logic a;
    bus_start;
    put_byte({DEV, 1'b0}, a); chk("R11 device write ACK", a, 1);
    put_byte(8'h02, a);       chk("R11 high address ACK", a, 1);
    bus_stop;
    read_run(1, "R11 pointer unchanged");
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_random;
    t_sequential;
    t_wrap;
    t_mismatch;
    t_master_nack;
    t_extra_write;
    t_cut_dummy;
    chk("R10 drive changes only with SCL low", viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule